// File: doc/BRIEF.md
# Framed Serial PCM Sample Port

This block connects a sample-processing core to a PCM codec over a framed serial link. The link carries two 8-bit companded sample lanes: the receive path and the transmit path. An 8 kHz frame sync marks each frame, and a bit clock between 64 kHz and 2048 kHz paces the bits. The core's system clock runs the whole block. The bit clock, the frame sync and both serial data inputs pass through a synchronizer chain before any edge is detected. For this reason the system clock must run at least eight times as fast as the bit clock.

At the start of each frame the block shifts in one byte per lane, most significant bit first. It then moves both bytes into parallel output registers and raises a load-detect pulse that lasts one bit-clock period. The falling edge of that pulse is meant to be fed back to the core as its start-of-processing strobe.

In the same frame slots, the block shifts out the two processed bytes most recently written by the core. The output enable is active only during the eight data slots. While the enable is low the pads are high impedance. Companding and echo processing happen elsewhere.

Top module: `ulaw_pcm_port`

## Requirements
- R1: While reset is asserted and after it is released, `so_en` and `load_det` are low and both parallel words read zero until the first captured frame.
- R2: Serial inputs are sampled on falling bit-clock edges. The first falling edge after a frame start supplies word bit 7, and the eighth supplies bit 0. Bits in later slots of the frame never reach the words.
- R3: A frame starts on a rising bit-clock edge at which `fsync` is high, provided `fsync` was low at the previous rising edge. A sync pulse held high for many slots starts only one frame.
- R4: `load_det` pulses exactly once per frame. It rises after the eighth falling edge and falls at the next falling edge, so it stays high for one bit-clock period. `rx_word` and `tx_word` change only in the cycle in which `load_det` rises.
- R5: `so_en` goes high at the frame-start rising edge and stays high for exactly eight bit slots. The serial outputs carry the byte most significant bit first and change only after rising bit-clock edges.
- R6: A cycle with `proc_we` high stores `rx_proc` and `tx_proc` in a holding register. The holding register is copied at each frame start. A write made during a frame affects only the next frame, and with no new write the same bytes are sent again.
- R7: While `sleep` is high, `so_en` and `load_det` stay low and no frame is captured or sent. The parallel words keep their values, and after `sleep` falls the next frame behaves normally.
- R8: Frames of exactly eight slots may follow each other with no gap. Every frame is still captured, pulsed and sent correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Power-down: serial side idle, pads released |
| bclk | input | 1 | Codec bit clock (asynchronous) |
| fsync | input | 1 | Codec frame sync (asynchronous) |
| rx_sd | input | 1 | Receive-path serial data in |
| tx_sd | input | 1 | Transmit-path serial data in |
| rx_proc | input | 8 | Processed receive-path byte to send |
| tx_proc | input | 8 | Processed transmit-path byte to send |
| proc_we | input | 1 | Write strobe for the two processed bytes |
| rx_word | output | 8 | Last captured receive-path byte |
| tx_word | output | 8 | Last captured transmit-path byte |
| load_det | output | 1 | One bit-clock pulse after a capture; falling edge starts processing |
| rx_so | output | 1 | Receive-path serial data out |
| tx_so | output | 1 | Transmit-path serial data out |
| so_en | output | 1 | Output drive enable; pads are high impedance when low |

## Verification
A slip in the input bit counter shows up within one frame. The captured word is then rotated, or `load_det` rises at the wrong falling edge, which changes the measured pulse width. A stuck output slot counter leaves `so_en` high past the eighth slot. A missed frame start drops an expected byte from the serial scoreboard. If the holding register is sampled at the wrong moment, the serial bytes lag or lead the writes by a frame, so the bench writes new bytes in the middle of a frame and checks the next two frames. A sync that retriggers during a long pulse shows up as an extra `load_det` pulse in the same frame.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned NCH    = 2;
    localparam int unsigned IDX_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef word_t [NCH-1:0]   lane_t;

    localparam idx_t LAST_IDX = idx_t'(WORD_W - 1);
endpackage

// File: rtl/pcm_sync_edge.sv
// Synchronizer chain for the codec-side signals. Bit 0 is the bit clock;
// its edges are reported, the remaining bits are passed on as levels.
module pcm_sync_edge #(
    parameter int STAGES = 2,
    parameter int N      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-2:0] data_out,
    output logic         clk_rise,
    output logic         clk_fall
);
    logic [N-1:0] stg_q [STAGES];
    logic         hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            hist_q <= 1'b0;
        end else begin
            stg_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            hist_q <= stg_q[STAGES-1][0];
        end
    end

    assign data_out = stg_q[STAGES-1][N-1:1];
    assign clk_rise = stg_q[STAGES-1][0] & ~hist_q;
    assign clk_fall = ~stg_q[STAGES-1][0] & hist_q;
endmodule

// File: rtl/pcm_deser.sv
// Input side: shifts in one byte per lane on falling bit-clock edges.
module pcm_deser import pcm_port_pkg::*; (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sleep,
    input  logic           frame_go,
    input  logic           bclk_fall,
    input  logic [NCH-1:0] sd,
    output lane_t          words,
    output logic           load_det
);
    typedef struct packed {
        logic  active;
        idx_t  cnt;
        lane_t sh;
        lane_t words;
        logic  ld;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (frame_go) begin
            d.active = 1'b1;
            d.cnt    = '0;
        end
        if (bclk_fall) begin
            d.ld = 1'b0;
            if (q.active) begin
                for (int ch = 0; ch < NCH; ch++)
                    d.sh[ch] = {q.sh[ch][WORD_W-2:0], sd[ch]};
                if (q.cnt == LAST_IDX) begin
                    d.active = 1'b0;
                    d.words  = d.sh;
                    d.ld     = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
        if (sleep) begin
            d.active = 1'b0;
            d.ld     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign words    = q.words;
    assign load_det = q.ld;
endmodule

// File: rtl/pcm_ser.sv
// Output side: loads the held bytes at frame start, shifts on rising edges.
module pcm_ser import pcm_port_pkg::*; (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sleep,
    input  logic           frame_go,
    input  logic           bclk_rise,
    input  lane_t          hold,
    output logic [NCH-1:0] so,
    output logic           so_en
);
    typedef struct packed {
        logic  en;
        idx_t  idx;
        lane_t sh;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (bclk_rise) begin
            if (frame_go) begin
                d.sh  = hold;
                d.en  = 1'b1;
                d.idx = '0;
            end else if (q.en) begin
                if (q.idx == LAST_IDX) begin
                    d.en = 1'b0;
                end else begin
                    d.idx = q.idx + 1'b1;
                    for (int ch = 0; ch < NCH; ch++)
                        d.sh[ch] = {q.sh[ch][WORD_W-2:0], 1'b0};
                end
            end
        end
        if (sleep) d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        assign so[ch] = q.sh[ch][WORD_W-1];
    end

    assign so_en = q.en;
endmodule

// File: rtl/ulaw_pcm_port.sv
module ulaw_pcm_port import pcm_port_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              rx_sd,
    input  logic              tx_sd,
    input  logic [WORD_W-1:0] rx_proc,
    input  logic [WORD_W-1:0] tx_proc,
    input  logic              proc_we,
    output logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] tx_word,
    output logic              load_det,
    output logic              rx_so,
    output logic              tx_so,
    output logic              so_en
);
    localparam int SIG_N = NCH + 2;

    typedef struct packed {
        lane_t hold;
        logic  sync_last;
    } st_t;

    st_t            q, d;
    logic [SIG_N-2:0] lvl;
    logic           bclk_rise, bclk_fall, frame_go;
    lane_t          words_l;
    logic [NCH-1:0] so_l;

    pcm_sync_edge #(.STAGES(SYNC_STAGES), .N(SIG_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({tx_sd, rx_sd, fsync, bclk}),
        .data_out (lvl),
        .clk_rise (bclk_rise),
        .clk_fall (bclk_fall)
    );

    always_comb begin
        d = q;
        if (proc_we) begin
            d.hold[0] = rx_proc;
            d.hold[1] = tx_proc;
        end
        if (bclk_rise) d.sync_last = lvl[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frame_go = bclk_rise & lvl[0] & ~q.sync_last & ~sleep;

    pcm_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .frame_go  (frame_go),
        .bclk_fall (bclk_fall),
        .sd        (lvl[NCH:1]),
        .words     (words_l),
        .load_det  (load_det)
    );

    pcm_ser u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .frame_go  (frame_go),
        .bclk_rise (bclk_rise),
        .hold      (q.hold),
        .so        (so_l),
        .so_en     (so_en)
    );

    assign rx_word = words_l[0];
    assign tx_word = words_l[1];
    assign rx_so   = so_l[0];
    assign tx_so   = so_l[1];
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk import pcm_port_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              bclk_rise,
    input logic              bclk_fall,
    input logic              frame_go,
    input logic              so_en,
    input logic              rx_so,
    input logic              tx_so,
    input logic              load_det,
    input logic [WORD_W-1:0] rx_word,
    input logic [WORD_W-1:0] tx_word
);
    logic [3:0] er_q;
    logic [1:0] fc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            er_q <= '0;
            fc_q <= '0;
        end else begin
            if (frame_go || !so_en)          er_q <= '0;
            else if (bclk_rise && er_q != 4'hF) er_q <= er_q + 4'd1;
            if (!load_det)                   fc_q <= '0;
            else if (bclk_fall && fc_q != 2'd3) fc_q <= fc_q + 2'd1;
        end
    end

    // R7
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!so_en && !load_det));

    // R5
    slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> (er_q <= 4'd7));

    // R5
    out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rx_so, tx_so}) |-> $past(bclk_rise));

    // R3
    en_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_en) |-> $past(frame_go));

    // R4
    ld_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_det |-> (fc_q < 2'd2));

    // R4
    word_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rx_word, tx_word}) |-> $rose(load_det));
endmodule

bind ulaw_pcm_port pcm_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .frame_go  (frame_go),
    .so_en     (so_en),
    .rx_so     (rx_so),
    .tx_so     (tx_so),
    .load_det  (load_det),
    .rx_word   (rx_word),
    .tx_word   (tx_word)
);

// File: tb/sim_ulaw_pcm_port.sv
`timescale 1ns/1ps
module sim_ulaw_pcm_port;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, sleep = 1'b0, bclk = 1'b0, fsync = 1'b0;
    logic       rx_sd = 1'b0, tx_sd = 1'b0, proc_we = 1'b0;
    logic [7:0] rx_proc = 8'h00, tx_proc = 8'h00;
    logic [7:0] rx_word, tx_word;
    logic       load_det, rx_so, tx_so, so_en;

    ulaw_pcm_port u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .bclk(bclk), .fsync(fsync),
        .rx_sd(rx_sd), .tx_sd(tx_sd), .rx_proc(rx_proc), .tx_proc(tx_proc),
        .proc_we(proc_we), .rx_word(rx_word), .tx_word(tx_word),
        .load_det(load_det), .rx_so(rx_so), .tx_so(tx_so), .so_en(so_en)
    );

    int n_chk = 0, n_fail = 0, ld_pulses = 0, quiet_bad = 0;
    bit done = 1'b0, mon_on = 1'b0;
    logic [15:0] exp_ser[$];
    logic [15:0] exp_par[$];
    logic [7:0]  hold_rx = 8'h00, hold_tx = 8'h00;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_hold(input logic [7:0] a, input logic [7:0] b);
        proc_we = 1'b1; rx_proc = a; tx_proc = b;
        @(negedge clk);
        proc_we = 1'b0;
        hold_rx = a; hold_tx = b;
    endtask

    // Driver: one frame of nslots bit periods, 16 system clocks each.
    task automatic run_frame(input int nslots, input int sync_w, input logic [7:0] rb,
                             input logic [7:0] tb, input bit mid_wr, input logic [7:0] na,
                             input logic [7:0] nb, input bit quiet);
        if (!quiet) begin
            exp_ser.push_back({hold_rx, hold_tx});
            exp_par.push_back({rb, tb});
        end
        for (int s = 0; s < nslots; s++) begin
            wait_clk(4);
            fsync = (s < sync_w);
            wait_clk(4);
            bclk = 1'b1;
            if (s < 8) begin
                rx_sd = rb[7-s];
                tx_sd = tb[7-s];
            end else begin
                rx_sd = 1'($urandom);
                tx_sd = 1'($urandom);
            end
            if (mid_wr && s == 3) begin
                write_hold(na, nb);
                wait_clk(7);
            end else begin
                wait_clk(8);
            end
            bclk = 1'b0;
            if (quiet && (so_en || load_det)) quiet_bad++;
            if (!quiet && s == 8)
                chk(!so_en, "R5 enable dropped after eighth slot", so_en, 0);
        end
    endtask

    // Monitor: serial output bytes, sampled as a codec would on falling edges.
    initial begin
        logic [7:0]  sa, sb;
        logic [15:0] e;
        int nbits;
        sa = '0; sb = '0; nbits = 0;
        forever begin
            @(negedge bclk);
            if (mon_on) begin
                if (so_en) begin
                    sa = {sa[6:0], rx_so};
                    sb = {sb[6:0], tx_so};
                    nbits++;
                    if (nbits == 8) begin
                        nbits = 0;
                        if (exp_ser.size() == 0) begin
                            chk(1'b0, "R5 unexpected serial byte", {sa, sb}, 0);
                        end else begin
                            e = exp_ser.pop_front();
                            chk({sa, sb} == e, "R6 serial bytes from holding register", {sa, sb}, e);
                        end
                    end
                end else if (nbits != 0) begin
                    chk(1'b0, "R5 output slot cut short", nbits, 8);
                    nbits = 0;
                end
            end
        end
    end

    // Monitor: parallel words and load-detect pulse width.
    initial begin
        logic        prev;
        int          w;
        logic [15:0] e;
        prev = 1'b0; w = 0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (load_det && !prev) begin
                    ld_pulses++;
                    w = 1;
                    if (exp_par.size() == 0) begin
                        chk(1'b0, "R4 unexpected load pulse", {rx_word, tx_word}, 0);
                    end else begin
                        e = exp_par.pop_front();
                        chk({rx_word, tx_word} == e, "R2 captured words", {rx_word, tx_word}, e);
                    end
                end else if (load_det) begin
                    w++;
                end else if (prev) begin
                    chk(w == 16, "R4 load pulse width in clocks", w, 16);
                end
            end
            prev = load_det;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int p;
        wait_clk(5);
        chk(!so_en, "R1 enable low in reset", so_en, 0);
        chk(!load_det, "R1 load low in reset", load_det, 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk({rx_word, tx_word} == 16'h0, "R1 words zero after reset", {rx_word, tx_word}, 0);
        chk(!so_en && !load_det, "R1 outputs idle after reset", {so_en, load_det}, 0);
        mon_on = 1'b1;

        write_hold(8'hA5, 8'h3C);
        run_frame(32, 1, 8'h96, 8'h0F, 1'b0, 8'h00, 8'h00, 1'b0);
        chk(ld_pulses == 1, "R4 one pulse for first frame", ld_pulses, 1);

        p = ld_pulses;
        run_frame(32, 20, 8'h81, 8'h7E, 1'b0, 8'h00, 8'h00, 1'b0);
        chk(ld_pulses == p + 1, "R3 long sync starts one frame", ld_pulses, p + 1);

        run_frame(32, 3, 8'hC4, 8'h29, 1'b1, 8'h5A, 8'hC3, 1'b0);
        run_frame(32, 1, 8'h3B, 8'hD2, 1'b0, 8'h00, 8'h00, 1'b0);

        p = ld_pulses;
        run_frame(8, 1, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
        run_frame(8, 1, 8'h01, 8'h80, 1'b1, 8'h12, 8'h34, 1'b0);
        run_frame(8, 1, 8'h55, 8'hAA, 1'b0, 8'h00, 8'h00, 1'b0);
        run_frame(32, 1, 8'h6C, 8'h93, 1'b0, 8'h00, 8'h00, 1'b0);
        chk(ld_pulses == p + 4, "R8 back-to-back frames each pulsed", ld_pulses, p + 4);

        wait_clk(8);
        sleep = 1'b1;
        quiet_bad = 0;
        p = ld_pulses;
        run_frame(16, 1, 8'hE7, 8'h18, 1'b0, 8'h00, 8'h00, 1'b1);
        chk(quiet_bad == 0, "R7 outputs idle in sleep", quiet_bad, 0);
        chk(ld_pulses == p, "R7 no capture in sleep", ld_pulses, p);
        chk({rx_word, tx_word} == 16'h6C93, "R7 words kept in sleep", {rx_word, tx_word}, 16'h6C93);
        sleep = 1'b0;
        wait_clk(8);
        run_frame(32, 1, 8'h2D, 8'hB6, 1'b0, 8'h00, 8'h00, 1'b0);

        wait_clk(40);
        chk(exp_ser.size() == 0, "R5 every serial byte seen", exp_ser.size(), 0);
        chk(exp_par.size() == 0, "R2 every captured word seen", exp_par.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule